// File: doc/BRIEF.md
# Interrupt Pin Redirection Delivery Engine

This block watches a set of interrupt input pins and turns activity on each pin into a routed interrupt message. Each pin has its own redirection entry, supplied by an external register file as flat configuration buses. The entry holds the vector, the delivery mode, the destination mode, the destination, the input polarity, the trigger mode and a mask bit. Raw pins are synchronised, corrected for polarity and then treated as edge-triggered or level-triggered sources.

Pending sources are offered one at a time on a valid/ready message port, lowest pin number first. For each pin the block reports a delivery-status bit and a remote-IRR bit back to the register file. Level-triggered sources wait for an end-of-interrupt that carries their vector before they can fire again.

Top module: `irq_redirect_engine`

## Requirements
- R1: The polarity-corrected level is the raw pin XOR its polarity bit, so polarity 0 means active high and polarity 1 means active low. A pin sitting at its inactive level produces no message, including the period just after reset.
- R2: An edge-triggered pin (trigger bit 0) raises exactly one message for each inactive-to-active transition, however long it then stays active.
- R3: A level-triggered pin (trigger bit 1) raises a message while it is active, unmasked and its remote IRR is 0. If the level is still active when remote IRR clears, it raises one further message.
- R4: An active edge that arrives while the pin's mask bit is 1 is discarded. Clearing the mask later produces no message for that edge.
- R5: A level-triggered pin that is active while masked is delivered once the mask is cleared, provided the level is still active.
- R6: A message carries the entry's 8-bit vector, its 3-bit delivery mode (000 fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT, 111 ExtINT) and its destination-mode bit, all unchanged. When the destination-mode bit is 0 (physical), the destination output is the low 4 bits of the entry's destination with bits 7:4 at zero. When it is 1 (logical), all 8 bits pass through.
- R7: A pin's delivery-status bit is 1 from the time its message is raised until the message is accepted, and 0 otherwise. All bits are 0 after reset.
- R8: Acceptance of a level-triggered message sets that pin's remote-IRR bit. The bit is cleared only by an end-of-interrupt whose vector equals the pin's vector, and an end-of-interrupt with any other vector leaves it set.
- R9: When several pins are pending, the lowest-numbered pin is offered first. At most one message is presented at a time, and its fields stay stable until msg_ready accepts it.
- R10: Raw pins pass through a two-flop synchronizer. A message cannot appear sooner than three clock edges after the raw pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | N | Raw interrupt pins, asynchronous |
| cfg_vector | input | 8*N | Per-pin vector, pin i at bits 8i+7:8i |
| cfg_mode | input | 3*N | Per-pin delivery mode |
| cfg_logical | input | N | Per-pin destination mode, 1 = logical |
| cfg_polarity | input | N | Per-pin polarity, 1 = active low |
| cfg_level | input | N | Per-pin trigger mode, 1 = level |
| cfg_mask | input | N | Per-pin mask, 1 = masked |
| cfg_dest | input | 8*N | Per-pin destination |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination after physical truncation |
| delivery_status | output | N | Per-pin raised-but-not-accepted flag |
| remote_irr | output | N | Per-pin level in-service flag |

## Verification
The assertions check the following on every cycle: an offered message holds steady until accepted, no more than one pin is granted in a cycle, a physical destination never carries upper bits, some delivery-status bit is set while a message is offered, and remote IRR only rises after a level-triggered grant. The bench scenarios are needed to show the rest. These are the lowest-pin ordering, edges dropped under mask, level re-delivery after a matching end-of-interrupt, the synchronizer latency, and the per-field routing under random entries.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;
  localparam int PHYS_W = 4;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    dmode_e            mode;
    logic              logical;
    logic [DEST_W-1:0] dest;
  } irq_msg_t;

  // physical targets keep only the low ID nibble
  function automatic logic [DEST_W-1:0] route_dest(input logic logical,
                                                   input logic [DEST_W-1:0] dest);
    logic [DEST_W-1:0] r;
    if (logical) r = dest;
    else         r = {{(DEST_W-PHYS_W){1'b0}}, dest[PHYS_W-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             settled,
  input  logic             pin_sync,
  input  logic             polarity,
  input  logic             level_mode,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             grant,
  input  logic             offered,
  output logic             request,
  output logic             remote_irr,
  output logic             delivery_status,
  output logic             edge_seen
);
  logic active;
  logic active_q;
  logic edge_pend;
  logic irr_q;
  logic eoi_hit;
  logic level_req;

  assign active    = pin_sync ^ polarity;
  assign edge_seen = settled & active & ~active_q;
  assign eoi_hit   = eoi_valid & irr_q & (eoi_vector == vector);
  assign level_req = settled & level_mode & active & ~mask & ~irr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      edge_pend <= 1'b0;
      irr_q     <= 1'b0;
    end else begin
      active_q <= active;
      if (level_mode)
        edge_pend <= 1'b0;
      else if (edge_seen && !mask)
        edge_pend <= 1'b1;
      else if (grant)
        edge_pend <= 1'b0;
      if (grant && level_mode)
        irr_q <= 1'b1;
      else if (eoi_hit)
        irr_q <= 1'b0;
    end
  end

  assign request         = (edge_pend & ~mask) | level_req;
  assign remote_irr      = irr_q;
  assign delivery_status = request | offered;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             ready,
  output logic             valid,
  output logic             lock_fire,
  output logic [IDX_W-1:0] next_idx,
  output logic [N-1:0]     grant,
  output logic [N-1:0]     offered
);
  logic [IDX_W-1:0] idx_q;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  assign next_idx  = lowest_set(req);
  assign lock_fire = ~valid & (|req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      idx_q <= '0;
    end else if (lock_fire) begin
      valid <= 1'b1;
      idx_q <= next_idx;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign offered[g] = valid & (idx_q == IDX_W'(g));
    assign grant[g]   = offered[g] & ready;
  end
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_route_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pin_raw,
  input  logic [N*VEC_W-1:0]  cfg_vector,
  input  logic [N*MODE_W-1:0] cfg_mode,
  input  logic [N-1:0]        cfg_logical,
  input  logic [N-1:0]        cfg_polarity,
  input  logic [N-1:0]        cfg_level,
  input  logic [N-1:0]        cfg_mask,
  input  logic [N*DEST_W-1:0] cfg_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [VEC_W-1:0]    msg_vector,
  output logic [MODE_W-1:0]   msg_mode,
  output logic                msg_logical,
  output logic [DEST_W-1:0]   msg_dest,
  output logic [N-1:0]        delivery_status,
  output logic [N-1:0]        remote_irr
);
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1;
  localparam int SETTLE  = 3;
  localparam int SET_W   = $clog2(SETTLE + 1);

  logic [N-1:0]     pin_sync;
  logic [N-1:0]     req_vec;
  logic [N-1:0]     grant_vec;
  logic [N-1:0]     offered_vec;
  logic [N-1:0]     edge_seen_vec;
  logic             lock_fire;
  logic [IDX_W-1:0] next_idx;
  logic [SET_W-1:0] warm_cnt;
  logic             settled;
  irq_msg_t         msg_q;

  // hold detection off until the synchronizer carries real pin values
  assign settled = (warm_cnt == SET_W'(SETTLE));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        warm_cnt <= '0;
    else if (!settled) warm_cnt <= warm_cnt + 1'b1;
  end

  irq_sync2 #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    irq_pin_slot u_slot (
      .clk             (clk),
      .rst_n           (rst_n),
      .settled         (settled),
      .pin_sync        (pin_sync[g]),
      .polarity        (cfg_polarity[g]),
      .level_mode      (cfg_level[g]),
      .mask            (cfg_mask[g]),
      .vector          (cfg_vector[g*VEC_W +: VEC_W]),
      .eoi_valid       (eoi_valid),
      .eoi_vector      (eoi_vector),
      .grant           (grant_vec[g]),
      .offered         (offered_vec[g]),
      .request         (req_vec[g]),
      .remote_irr      (remote_irr[g]),
      .delivery_status (delivery_status[g]),
      .edge_seen       (edge_seen_vec[g])
    );
  end

  irq_pick #(.N(N)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_vec),
    .ready     (msg_ready),
    .valid     (msg_valid),
    .lock_fire (lock_fire),
    .next_idx  (next_idx),
    .grant     (grant_vec),
    .offered   (offered_vec)
  );

  function automatic irq_msg_t build_msg(input logic [IDX_W-1:0] p,
                                         input logic [N*VEC_W-1:0]  vecs,
                                         input logic [N*MODE_W-1:0] modes,
                                         input logic [N-1:0]        logicals,
                                         input logic [N*DEST_W-1:0] dests);
    irq_msg_t m;
    m.vector  = vecs[p*VEC_W +: VEC_W];
    m.mode    = dmode_e'(modes[p*MODE_W +: MODE_W]);
    m.logical = logicals[p];
    m.dest    = route_dest(logicals[p], dests[p*DEST_W +: DEST_W]);
    return m;
  endfunction

  // fields are captured at lock time so they cannot move while offered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      msg_q <= '0;
    else if (lock_fire)
      msg_q <= build_msg(next_idx, cfg_vector, cfg_mode, cfg_logical, cfg_dest);
  end

  assign msg_vector  = msg_q.vector;
  assign msg_mode    = msg_q.mode;
  assign msg_logical = msg_q.logical;
  assign msg_dest    = msg_q.dest;
endmodule

// File: rtl/irq_redirect_checker.sv
module irq_redirect_checker #(
  parameter int N = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [7:0]   msg_vector,
  input logic [2:0]   msg_mode,
  input logic         msg_logical,
  input logic [7:0]   msg_dest,
  input logic [N-1:0] delivery_status,
  input logic [N-1:0] remote_irr,
  input logic [N-1:0] grant_vec,
  input logic [N-1:0] cfg_level
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_vector, msg_mode, msg_logical, msg_dest}));

  assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_phys_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical |-> msg_dest[7:4] == 4'h0);

  assert_status_offered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> delivery_status != '0);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_irr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_irr[g]) |-> $past(grant_vec[g] && cfg_level[g]));
  end
endmodule

bind irq_redirect_engine irq_redirect_checker #(.N(N)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .msg_valid       (msg_valid),
  .msg_ready       (msg_ready),
  .msg_vector      (msg_vector),
  .msg_mode        (msg_mode),
  .msg_logical     (msg_logical),
  .msg_dest        (msg_dest),
  .delivery_status (delivery_status),
  .remote_irr      (remote_irr),
  .grant_vec       (grant_vec),
  .cfg_level       (cfg_level)
);

// File: tb/test_irq_redirect_engine.sv
`timescale 1ns/1ps
module test_irq_redirect_engine;
  localparam int N = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pin_raw;
  logic [N*8-1:0] cfg_vector;
  logic [N*3-1:0] cfg_mode;
  logic [N-1:0]   cfg_logical, cfg_polarity, cfg_level, cfg_mask;
  logic [N*8-1:0] cfg_dest;
  logic           eoi_valid = 1'b0;
  logic [7:0]     eoi_vector = 8'h00;
  logic           msg_valid;
  logic           msg_ready = 1'b0;
  logic [7:0]     msg_vector;
  logic [2:0]     msg_mode;
  logic           msg_logical;
  logic [7:0]     msg_dest;
  logic [N-1:0]   delivery_status, remote_irr;

  logic [7:0] t_vec [N];
  logic [2:0] t_mode[N];
  logic [7:0] t_dest[N];
  logic       t_log [N];
  logic       t_pol [N];
  logic       t_lvl [N];
  logic       t_msk [N];
  logic       t_raw [N];

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_vector[i*8 +: 8] = t_vec[i];
      cfg_mode[i*3 +: 3]   = t_mode[i];
      cfg_dest[i*8 +: 8]   = t_dest[i];
      cfg_logical[i]       = t_log[i];
      cfg_polarity[i]      = t_pol[i];
      cfg_level[i]         = t_lvl[i];
      cfg_mask[i]          = t_msk[i];
      pin_raw[i]           = t_raw[i];
    end
  end

  irq_redirect_engine #(.N(N)) i_irq_redirect_engine (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_dest(input int p);
    return t_log[p] ? t_dest[p] : {4'h0, t_dest[p][3:0]};
  endfunction

  function automatic logic [2:0] legal_mode(input int k);
    case (k % 6)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b100;
      4: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (msg_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic take();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic check_msg(input int p, input string req);
    chk(msg_vector == t_vec[p], req, msg_vector, t_vec[p]);
    chk(msg_mode == t_mode[p], req, msg_mode, t_mode[p]);
    chk(msg_logical == t_log[p], req, msg_logical, t_log[p]);
    chk(msg_dest == exp_dest(p), req, msg_dest, exp_dest(p));
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (msg_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic pin_on(input int p);  t_raw[p] = ~t_pol[p]; endtask
  task automatic pin_off(input int p); t_raw[p] =  t_pol[p]; endtask

  task automatic send_eoi(input logic [7:0] v);
    eoi_vector = v;
    eoi_valid  = 1'b1;
    @(negedge clk);
    eoi_valid  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit got;
    void'($urandom(32'd4021));
    for (int i = 0; i < N; i++) begin
      t_vec[i]  = 8'h20 + 8'(i);
      t_mode[i] = legal_mode($urandom_range(0, 5));
      t_dest[i] = 8'($urandom);
      t_log[i]  = 1'($urandom);
      t_pol[i]  = 1'($urandom);
      t_lvl[i]  = 1'b0;
      t_msk[i]  = 1'b0;
    end
    t_pol[5] = 1'b1;
    t_pol[6] = 1'b0;
    for (int i = 0; i < N; i++) t_raw[i] = t_pol[i];

    cyc(5);
    chk(msg_valid == 1'b0, "R9 reset valid", msg_valid, 0);
    chk(delivery_status == '0, "R7 reset status", delivery_status, 0);
    chk(remote_irr == '0, "R8 reset irr", remote_irr, 0);
    rst_n = 1'b1;
    quiet(12, "R1 idle pins after reset");

    // R10 latency and R2 single message per edge
    pin_on(3);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R10 edge+1", msg_valid, 0);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R10 edge+2", msg_valid, 0);
    wait_msg(got);
    chk(got, "R2 edge message", got, 1);
    check_msg(3, "R6 pin3 fields");
    chk(delivery_status[3], "R7 status while offered", delivery_status[3], 1);
    take();
    chk(!delivery_status[3], "R7 status after accept", delivery_status[3], 0);
    chk(!remote_irr[3], "R8 edge keeps irr clear", remote_irr[3], 0);
    quiet(10, "R2 held level no repeat");
    pin_off(3);
    quiet(5, "R2 release no message");

    // R1 active-low pin
    pin_on(5);
    wait_msg(got);
    chk(got && msg_vector == t_vec[5], "R1 active-low fires", msg_vector, t_vec[5]);
    take();
    pin_off(5);
    quiet(8, "R1 active-low release");

    // R4 masked edge is dropped
    t_msk[7] = 1'b1;
    pin_on(7);
    cyc(8);
    t_msk[7] = 1'b0;
    quiet(10, "R4 masked edge dropped");
    pin_off(7);
    cyc(5);

    // R5, R3, R8 level pin
    t_lvl[9] = 1'b1;
    t_msk[9] = 1'b1;
    pin_on(9);
    quiet(8, "R5 masked level held off");
    chk(!delivery_status[9], "R7 masked level status", delivery_status[9], 0);
    t_msk[9] = 1'b0;
    wait_msg(got);
    chk(got, "R5 level after unmask", got, 1);
    check_msg(9, "R6 pin9 fields");
    take();
    chk(remote_irr[9], "R8 irr set on accept", remote_irr[9], 1);
    chk(!delivery_status[9], "R7 level status after accept", delivery_status[9], 0);
    quiet(8, "R3 no repeat while irr");
    send_eoi(8'h55);
    chk(remote_irr[9], "R8 wrong eoi ignored", remote_irr[9], 1);
    quiet(6, "R8 wrong eoi no message");
    send_eoi(t_vec[9]);
    wait_msg(got);
    chk(got && msg_vector == t_vec[9], "R3 redelivery after eoi", msg_vector, t_vec[9]);
    take();
    pin_off(9);
    cyc(5);
    send_eoi(t_vec[9]);
    chk(!remote_irr[9], "R8 matching eoi clears", remote_irr[9], 0);
    quiet(8, "R3 inactive level silent");
    t_lvl[9] = 1'b0;

    // R9 ordering and hold
    pin_on(15); pin_on(2); pin_on(11);
    wait_msg(got);
    for (int k = 0; k < 5; k++) begin
      chk(msg_valid && msg_vector == t_vec[2], "R9 lowest held", msg_vector, t_vec[2]);
      @(negedge clk);
    end
    take();
    wait_msg(got);
    chk(got && msg_vector == t_vec[11], "R9 second pin", msg_vector, t_vec[11]);
    take();
    wait_msg(got);
    chk(got && msg_vector == t_vec[15], "R9 third pin", msg_vector, t_vec[15]);
    take();
    pin_off(15); pin_off(2); pin_off(11);
    quiet(6, "R9 drained");

    // random entries
    for (int it = 0; it < 40; it++) begin
      int p;
      p = $urandom_range(0, N - 1);
      t_mode[p] = legal_mode($urandom_range(0, 5));
      t_dest[p] = 8'($urandom);
      t_log[p]  = 1'($urandom);
      t_lvl[p]  = 1'($urandom);
      cyc(1);
      pin_on(p);
      wait_msg(got);
      chk(got, "R2 random delivery", got, 1);
      check_msg(p, "R6 random fields");
      take();
      chk(remote_irr[p] == t_lvl[p], "R8 random irr", remote_irr[p], t_lvl[p]);
      pin_off(p);
      cyc(5);
      if (t_lvl[p]) begin
        send_eoi(t_vec[p]);
        chk(!remote_irr[p], "R8 random eoi", remote_irr[p], 0);
      end
      quiet(4, "R3 random quiet");
      t_lvl[p] = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule